// File: doc/BRIEF.md
# External Bus Cycle Stretcher

This block times one read or write cycle to external data memory. A one-clock start request launches an access. The access lasts a whole number of machine cycles: two, plus a 3-bit stretch count of zero to seven. The read strobe or the write strobe is held low for the added cycles, so slow memory or peripherals get more time. The code that issues the access needs no change; it only waits longer.

A machine cycle is a parameter number of oscillator clocks, four by default. When the request targets on-chip data memory, the stretch count is ignored and the access takes the minimum two machine cycles. The stretch count and the read/write choice are captured with the start request. `busy` covers the whole access, and `done` marks its last clock. The stretch configuration held outside this block resets to 001, so an access that has not been configured takes three machine cycles.

Top module: `xmem_stretch`

## Requirements
- R1: While `rst_n` is low, and after it is released until a start is accepted, `rd_n` and `wr_n` are 1 and `busy` and `done` are 0.
- R2: A `start` seen high on a rising edge while `busy` is 0 sets `busy` from the next clock. `busy` then stays high for exactly 4×(2+S) clocks, where S is the value of `stretch_cfg` at that edge.
- R3: With `onchip` high at the start edge, the access lasts 8 clocks (2 machine cycles) whatever `stretch_cfg` holds.
- R4: Changes to `stretch_cfg`, `wr_sel` or `onchip` after the start edge do not change the length or the strobe of the access in progress.
- R5: The active strobe is low from clock 4 of the access (the start of the second machine cycle) through its last clock. Its width is 4×(1+S) clocks, or 4 clocks for an on-chip access. Outside an access both strobes are 1.
- R6: `wr_sel`=0 selects a read, which drives `rd_n` only. `wr_sel`=1 selects a write, which drives `wr_n` only. The two strobes are never low together.
- R7: `done` is high for exactly one clock, the last clock of the access in which `busy` is high. `busy` is 0 on the following clock.
- R8: A `start` seen while `busy` is high is ignored, including in the clock where `done` is high. It neither lengthens nor restarts the access.
- R9: With `stretch_cfg`=001, the configuration reset value, an external access lasts 12 clocks (3 machine cycles).
- R10: With `stretch_cfg`=000, an external access lasts 8 clocks and its strobe is low for 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stretch_cfg | input | 3 | Extra machine cycles S, 0 to 7 |
| start | input | 1 | Access request, sampled while idle |
| wr_sel | input | 1 | 1 = write, 0 = read |
| onchip | input | 1 | Target is on-chip memory; stretch ignored |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | High for the whole access |
| done | output | 1 | One-clock pulse on the last clock of the access |

## Verification
The embedded assertions take only synchronous inputs for granted. They let `start`, `wr_sel`, `onchip` and `stretch_cfg` change on any clock, so they hold even when a request arrives in the middle of an access. The stimulus changes inputs only on the falling edge. It deliberately changes the stretch value, the direction and the target during an access, and it raises `start` during an access and on its `done` clock. It also drives stretch values 0, 1 and 7 to reach the shortest, default and longest external lengths.

// File: rtl/xmem_stretch.sv
module xmem_stretch #(
  parameter int CLKS_PER_MC = 4,
  parameter int STRETCH_W   = 3,
  parameter int BASE_MC     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [STRETCH_W-1:0] stretch_cfg,
  input  logic                 start,
  input  logic                 wr_sel,
  input  logic                 onchip,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic                 busy,
  output logic                 done
);

  localparam int PH_W  = (CLKS_PER_MC > 1) ? $clog2(CLKS_PER_MC) : 1;
  localparam int LEN_W = STRETCH_W + 1;
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(CLKS_PER_MC - 1);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(BASE_MC);

  logic [PH_W-1:0]  phase;
  logic [LEN_W-1:0] mc_idx;
  logic [LEN_W-1:0] mc_len;
  logic             is_wr;
  logic             last_clk;
  logic             strobe;

  assign last_clk = busy && (phase == PH_LAST) && (mc_idx == mc_len - LEN_W'(1));
  assign strobe   = busy && (mc_idx != '0);
  assign done     = last_clk;
  assign rd_n     = ~(strobe && !is_wr);
  assign wr_n     = ~(strobe && is_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= '0;
      mc_idx <= '0;
      mc_len <= LEN_MIN;
      is_wr  <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        phase  <= '0;
        mc_idx <= '0;
        mc_len <= onchip ? LEN_MIN : LEN_MIN + LEN_W'(stretch_cfg);
        is_wr  <= wr_sel;
      end
    end else if (phase == PH_LAST) begin
      phase <= '0;
      if (last_clk) busy <= 1'b0;
      else          mc_idx <= mc_idx + LEN_W'(1);
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_strobe_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> busy);

  assert_first_mc_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (rd_n && wr_n));

  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  assert_fall_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: tb/xmem_stretch_bench.sv
module xmem_stretch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] stretch_cfg = 3'd1;
  logic       start = 1'b0;
  logic       wr_sel = 1'b0;
  logic       onchip = 1'b0;
  logic       rd_n, wr_n, busy, done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xmem_stretch u_xmem_stretch (
    .clk(clk), .rst_n(rst_n), .stretch_cfg(stretch_cfg), .start(start),
    .wr_sel(wr_sel), .onchip(onchip), .rd_n(rd_n), .wr_n(wr_n),
    .busy(busy), .done(done)
  );

  // behavioural reference: clock index within the access
  int m_busy = 0, m_k = 0, m_len = 0, m_wr = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_k = 0;
    end else if (m_busy == 0) begin
      if (start) begin
        m_busy = 1; m_k = 0;
        m_len = onchip ? 8 : 4 * (2 + int'(stretch_cfg));
        m_wr = int'(wr_sel);
      end
    end else if (m_k == m_len - 1) begin
      m_busy = 0;
    end else begin
      m_k++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  bit compare_on = 1'b0;
  always @(negedge clk) begin
    if (compare_on) begin
      int strobe_e;
      strobe_e = (m_busy == 1 && m_k >= 4) ? 1 : 0;
      check("R2 busy", int'(busy), m_busy);
      check("R7 done", int'(done), (m_busy == 1 && m_k == m_len - 1) ? 1 : 0);
      check("R6 rd_n", int'(rd_n), (strobe_e == 1 && m_wr == 0) ? 0 : 1);
      check("R5 wr_n", int'(wr_n), (strobe_e == 1 && m_wr == 1) ? 0 : 1);
    end
  end

  // run one access; optionally disturb inputs at a given busy clock
  task automatic access(input int s, input bit w, input bit oc, input int poke_at,
                        output int blen, output int slen, output int sfirst);
    @(negedge clk);
    stretch_cfg = 3'(s); wr_sel = w; onchip = oc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    blen = 0; slen = 0; sfirst = -1;
    while (busy) begin
      if (!rd_n || !wr_n) begin
        if (sfirst < 0) sfirst = blen;
        slen++;
      end
      if (blen == poke_at) begin
        stretch_cfg = ~stretch_cfg; wr_sel = ~wr_sel; onchip = ~onchip; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) start = 1'b1;
      blen++;
      @(negedge clk);
    end
    start = 1'b0;
    stretch_cfg = 3'd1; onchip = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int bl, sl, sf;
    repeat (3) @(negedge clk);
    check("R1 rd_n reset", int'(rd_n), 1);
    check("R1 wr_n reset", int'(wr_n), 1);
    check("R1 busy reset", int'(busy), 0);
    check("R1 done reset", int'(done), 0);
    rst_n = 1'b1;
    compare_on = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after release", int'(busy), 0);

    access(1, 1'b0, 1'b0, -1, bl, sl, sf);
    check("R9 default length", bl, 12);
    check("R5 default strobe width", sl, 8);
    check("R5 strobe starts mc1", sf, 4);

    access(0, 1'b1, 1'b0, -1, bl, sl, sf);
    check("R10 zero stretch length", bl, 8);
    check("R10 zero stretch strobe", sl, 4);

    access(7, 1'b0, 1'b0, -1, bl, sl, sf);
    check("R2 max stretch length", bl, 36);
    check("R5 max stretch strobe", sl, 32);

    access(7, 1'b1, 1'b1, -1, bl, sl, sf);
    check("R3 onchip length", bl, 8);
    check("R3 onchip strobe", sl, 4);

    access(2, 1'b1, 1'b0, 5, bl, sl, sf);
    check("R4 length held", bl, 16);
    check("R8 start mid access ignored", sl, 12);
    check("R8 idle after done-cycle start", int'(busy), 0);

    for (int s = 3; s <= 6; s++) begin
      access(s, s[0], 1'b0, -1, bl, sl, sf);
      check("R2 length sweep", bl, 4 * (2 + s));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule